// File: doc/BRIEF.md
# Quad SPI Flash Command Responder

This block is the target-side command front end of a serial NOR flash. It watches chip select, the serial clock and four bidirectional data lanes, and it decodes the commands a host sends. It holds the protocol state that decides how many lanes each part of a command uses. That state covers three things: whether the device is in single-line extended mode or all-quad mode, whether 4-byte addressing is active, and whether continuous-read mode is active. The same opcode can therefore be decoded differently, or rejected, depending on the current state.

The block answers identification and status reads. It accepts a small configuration register that sets the dummy-cycle count and an inhibit bit for continuous reads. It serves quad fast reads from a computed stand-in for the flash array. Chip select, serial clock and input lanes are sampled on the system clock. The serial clock must stay at or below a quarter of the system clock rate. Inputs are captured when the serial clock rises, and outputs change when it falls.

Top module: `qspi_flash_responder`

## Requirements
- R1: After power-on reset the device is in extended mode, with 3-byte addressing, continuous read off, dummy count 8 and inhibit clear; all output enables are low.
- R2: In extended mode, opcode 0x9F sent on io[0] returns the identification bytes 0x20, 0xBA, 0x19, repeating, MSB first on io[1].
- R3: Opcode 0x05 returns a status byte, repeated, with bit0 = all-quad mode, bit1 = 4-byte addressing, bit2 = continuous read, other bits 0. It is 1-1-1 in extended mode and 4-4-4 in all-quad mode.
- R4: Opcode 0xEB is accepted as 1-4-4 in extended mode. It takes the address MSB first, two mode clocks and the configured number of dummy clocks, all on io[3:0]. Data follows with the high nibble first. Byte k equals a[7:0]^a[15:8]^a[23:16]^a[31:24]^0x5A for address a = start+k.
- R5: Opcode 0x81 followed by one data byte writes the configuration. Bits 7:4 set the dummy count and bit 3 sets the continuous-read inhibit. The reset value is 0x80.
- R6: A fast-read mode byte whose upper nibble is 0xA enters or keeps continuous read. The next transaction then starts directly with address cycles. Any other mode byte leaves continuous read after the current transfer.
- R7: While the inhibit bit is set, a mode byte of 0xA0 does not enter continuous read, and the next transaction is decoded from an opcode.
- R8: Opcode 0xB7 enters and 0xE9 leaves 4-byte addressing. The setting persists across transactions, and while it is set fast reads take 4 address bytes.
- R9: Opcode 0x35 in extended mode enters all-quad mode. Opcode 0xF5 in all-quad mode leaves it. In all-quad mode the opcode, address and data all use four lanes.
- R10: In all-quad mode, commands sent with a single-line opcode and the opcode 0x9F are ignored, with output enables kept low. Opcode 0xAF returns the ID in 4-4-4. In extended mode, 0xAF is ignored.
- R11: Raising chip select mid-command aborts the command without changing the mode state.
- R12: Output lanes change only after a falling serial clock edge. The first data piece appears on the fall that follows the last address, mode or dummy rise.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock used to sample the serial pins |
| rst_n | input | 1 | Active-low power-on reset |
| cs_n | input | 1 | Active-low chip select |
| sclk | input | 1 | Serial clock |
| io_in | input | 4 | Input values of data lanes io[3:0] |
| io_out | output | 4 | Output values of data lanes |
| io_oe | output | 4 | Per-lane output enable |

## Verification
The bench targets the state-dependent decode. It sends 0x9F on one line after entering all-quad mode. A design that keeps decoding on single lanes there would answer with the ID instead of staying silent. It also sends an address-first transaction after a 0xA0 mode byte. A design that misses continuous read would treat the first address byte as an opcode and return the wrong bytes. The bench further covers the inhibit bit, a read with 4-byte addressing whose fourth address byte would be lost by a design that forgot the mode, and an aborted command. A design that failed to reset its decoder after the abort would corrupt the status read that follows it.

// File: rtl/qspi_flash_responder.sv
module qspi_flash_responder #(
  parameter logic [23:0] ID_CODE   = 24'h20BA19,
  parameter logic [4:0]  CFG_RESET = 5'b10000
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       cs_n,
  input  logic       sclk,
  input  logic [3:0] io_in,
  output logic [3:0] io_out,
  output logic [3:0] io_oe
);

  typedef enum logic [2:0] {P_OPC, P_ADDR, P_MODE, P_DUMMY, P_DOUT, P_DIN, P_IGN} phase_t;
  typedef enum logic [1:0] {S_ID, S_STAT, S_MEM} src_t;

  phase_t      phase;
  src_t        src;
  logic [4:0]  cnt, last;
  logic [31:0] sh, sh_nx, addr;
  logic [7:0]  obuf;
  logic [2:0]  opos;
  logic [1:0]  idx;
  logic        qpi, a4, crm, dq, sclk_q;
  logic [4:0]  cfg;   // [4:1] dummy count, [0] continuous-read inhibit

  wire rise = sclk & ~sclk_q;
  wire fall = ~sclk & sclk_q;
  wire in_q = (phase == P_OPC || phase == P_DIN) ? qpi : 1'b1;
  wire [7:0] status = {5'b0, crm, a4, qpi};

  assign sh_nx = in_q ? {sh[27:0], io_in} : {sh[30:0], io_in[0]};
  assign io_oe = (!cs_n && phase == P_DOUT) ? (dq ? 4'hF : 4'b0010) : 4'h0;

  function automatic logic [7:0] memb(input logic [31:0] a);
    return a[7:0] ^ a[15:8] ^ a[23:16] ^ a[31:24] ^ 8'h5A;
  endfunction

  function automatic logic [7:0] idbyte(input logic [1:0] i);
    case (i)
      2'd0:    return ID_CODE[23:16];
      2'd1:    return ID_CODE[15:8];
      default: return ID_CODE[7:0];
    endcase
  endfunction

  always_comb begin
    case (phase)
      P_OPC, P_DIN: last = qpi ? 5'd1 : 5'd7;
      P_ADDR:       last = a4 ? 5'd7 : 5'd5;
      P_MODE:       last = 5'd1;
      P_DUMMY:      last = {1'b0, cfg[4:1]} - 5'd1;
      default:      last = 5'd31;
    endcase
  end

  wire done = (cnt == last);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      phase <= P_OPC; src <= S_STAT; cnt <= '0; sh <= '0; addr <= '0;
      obuf <= '0; opos <= '0; idx <= '0; qpi <= 1'b0; a4 <= 1'b0;
      crm <= 1'b0; dq <= 1'b0; sclk_q <= 1'b0; cfg <= CFG_RESET; io_out <= '0;
    end else begin
      sclk_q <= sclk;
      if (cs_n) begin
        phase <= crm ? P_ADDR : P_OPC;
        cnt   <= '0;
        dq    <= crm | qpi;
      end else if (rise && phase != P_DOUT && phase != P_IGN) begin
        sh  <= sh_nx;
        cnt <= done ? 5'd0 : cnt + 5'd1;
        if (done) begin
          case (phase)
            P_OPC: begin
              phase <= P_IGN;
              case (sh_nx[7:0])
                8'h9F, 8'hAF:
                  if ((sh_nx[7:0] == 8'hAF) == qpi) begin
                    phase <= P_DOUT; src <= S_ID; idx <= 2'd0;
                    obuf <= ID_CODE[23:16]; opos <= '0;
                  end
                8'h05: begin phase <= P_DOUT; src <= S_STAT; obuf <= status; opos <= '0; end
                8'hEB: begin phase <= P_ADDR; dq <= 1'b1; end
                8'h35: if (!qpi) qpi <= 1'b1;
                8'hF5: if (qpi) qpi <= 1'b0;
                8'hB7: a4 <= 1'b1;
                8'hE9: a4 <= 1'b0;
                8'h81: phase <= P_DIN;
                default: ;
              endcase
            end
            P_ADDR: begin
              addr  <= a4 ? sh_nx : {8'h0, sh_nx[23:0]};
              phase <= P_MODE;
            end
            P_MODE: begin
              crm <= (sh_nx[7:4] == 4'hA) && !cfg[0];
              if (cfg[4:1] == 4'd0) begin
                phase <= P_DOUT; src <= S_MEM; obuf <= memb(addr); opos <= '0;
              end else phase <= P_DUMMY;
            end
            P_DUMMY: begin
              phase <= P_DOUT; src <= S_MEM; obuf <= memb(addr); opos <= '0;
            end
            P_DIN: begin cfg <= sh_nx[7:3]; phase <= P_IGN; end
            default: ;
          endcase
        end
      end else if (fall && phase == P_DOUT) begin
        io_out <= dq ? (opos[0] ? obuf[3:0] : obuf[7:4]) : {2'b0, obuf[3'd7 - opos], 1'b0};
        if (opos == (dq ? 3'd1 : 3'd7)) begin
          opos <= '0;
          case (src)
            S_ID: begin
              idx  <= (idx == 2'd2) ? 2'd0 : idx + 2'd1;
              obuf <= idbyte((idx == 2'd2) ? 2'd0 : idx + 2'd1);
            end
            S_STAT: obuf <= status;
            default: begin addr <= addr + 32'd1; obuf <= memb(addr + 32'd1); end
          endcase
        end else opos <= opos + 3'd1;
      end
    end
  end

  p_out_on_fall_r12: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(io_out) |-> $past(fall));
  p_quad_sel_r9: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(qpi) |-> $past(!cs_n && rise));
  p_addr4_sel_r8: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(a4) |-> $past(!cs_n && rise));
  p_cfg_sel_r5: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(cfg) |-> $past(!cs_n && rise));
  p_crm_inhibit_r7: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(crm) |-> !$past(cfg[0]));

endmodule

// File: tb/qspi_flash_responder_tb.sv
module qspi_flash_responder_tb;
  logic clk = 1'b0, rst_n = 1'b0, cs_n = 1'b1, sclk = 1'b0;
  logic [3:0] io_in = 4'h0;
  logic [3:0] io_out, io_oe;
  int n_chk = 0, n_fail = 0;

  bit m_qpi = 0, m_a4 = 0, m_crm = 0, m_inh = 0;
  int m_dummy = 8;

  always #2 clk = ~clk;

  qspi_flash_responder u_dut (.clk(clk), .rst_n(rst_n), .cs_n(cs_n), .sclk(sclk),
    .io_in(io_in), .io_out(io_out), .io_oe(io_oe));

  function automatic logic [7:0] memb(input logic [31:0] a);
    return a[7:0] ^ a[15:8] ^ a[23:16] ^ a[31:24] ^ 8'h5A;
  endfunction

  function automatic logic [7:0] mstat();
    return {5'b0, m_crm, m_a4, m_qpi};
  endfunction

  task automatic check(input string r, input bit ok, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", r, act, exp);
    end
  endtask

  task automatic clk_in(input logic [3:0] v);
    @(negedge clk) sclk = 1'b0; io_in = v;
    repeat (4) @(negedge clk);
    sclk = 1'b1;
    repeat (4) @(negedge clk);
  endtask

  task automatic send(input logic [7:0] b, input bit q);
    if (q) begin clk_in(b[7:4]); clk_in(b[3:0]); end
    else for (int i = 7; i >= 0; i--) clk_in({3'b0, b[i]});
  endtask

  task automatic recv(input string r, input bit q, input logic [7:0] exp);
    logic [7:0] b = '0;
    bit oe_ok = 1;
    for (int i = 0; i < (q ? 2 : 8); i++) begin
      @(negedge clk) sclk = 1'b0;
      repeat (4) @(negedge clk);
      b = q ? {b[3:0], io_out} : {b[6:0], io_out[1]};
      if (io_oe != (q ? 4'hF : 4'b0010)) oe_ok = 0;
      sclk = 1'b1;
      repeat (4) @(negedge clk);
    end
    check(r, b == exp && oe_ok, {io_oe, 20'h0, b}, {(q ? 4'hF : 4'h2), 20'h0, exp});
  endtask

  task automatic quiet(input string r, input int n);
    bit ok = 1;
    for (int i = 0; i < n; i++) begin
      @(negedge clk) sclk = 1'b0;
      repeat (4) @(negedge clk);
      if (io_oe != 4'h0) ok = 0;
      sclk = 1'b1;
      repeat (4) @(negedge clk);
    end
    check(r, ok, {28'h0, io_oe}, 32'h0);
  endtask

  task automatic cs_lo();
    @(negedge clk) cs_n = 1'b0;
    repeat (2) @(negedge clk);
  endtask

  task automatic cs_hi();
    @(negedge clk) cs_n = 1'b1;
    repeat (2) @(negedge clk);
    sclk = 1'b0; io_in = 4'h0;
    repeat (4) @(negedge clk);
  endtask

  task automatic cmd(input logic [7:0] op);
    cs_lo(); send(op, m_qpi); cs_hi();
  endtask

  task automatic rd_status(input string r);
    cs_lo(); send(8'h05, m_qpi);
    recv(r, m_qpi, mstat()); recv(r, m_qpi, mstat());
    cs_hi();
  endtask

  task automatic wr_cfg(input logic [7:0] v);
    cs_lo(); send(8'h81, m_qpi); send(v, m_qpi); cs_hi();
    m_dummy = v[7:4]; m_inh = v[3];
  endtask

  task automatic rd_fast(input string r, input logic [31:0] a, input logic [7:0] md, input int n);
    cs_lo();
    if (!m_crm) send(8'hEB, m_qpi);
    if (m_a4) send(a[31:24], 1);
    send(a[23:16], 1); send(a[15:8], 1); send(a[7:0], 1);
    send(md, 1);
    for (int i = 0; i < m_dummy; i++) clk_in(4'h0);
    for (int i = 0; i < n; i++) recv(r, 1, memb((m_a4 ? a : {8'h0, a[23:0]}) + i));
    cs_hi();
    m_crm = (md[7:4] == 4'hA) && !m_inh;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    n_fail++; n_chk++;
    $display("FAIL watchdog expired");
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    repeat (5) @(negedge clk);
    check("R1 oe after reset", io_oe == 4'h0, {28'h0, io_oe}, 32'h0);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    check("R1 oe idle", io_oe == 4'h0, {28'h0, io_oe}, 32'h0);
    rd_status("R1 R3 status after reset");
    // R2: ID in extended mode with wrap
    cs_lo(); send(8'h9F, 0);
    recv("R2 id0", 0, 8'h20); recv("R2 id1", 0, 8'hBA);
    recv("R2 id2", 0, 8'h19); recv("R2 id wrap", 0, 8'h20);
    cs_hi();
    rd_fast("R4 quad read 1-4-4 dummy 8", 32'h000123, 8'hFF, 3);
    wr_cfg(8'h40);
    rd_fast("R5 read with dummy 4", 32'h00ABCD, 8'h00, 2);
    // R6: continuous read entry, address-first, exit
    rd_fast("R6 entering read", 32'h000200, 8'hA0, 1);
    check("R6 model crm", m_crm == 1, 32'(m_crm), 32'h1);
    rd_fast("R6 address-first read", 32'h000010, 8'h00, 2);
    rd_status("R6 status after exit");
    // R7: inhibit
    wr_cfg(8'h48);
    rd_fast("R7 read with A0 inhibited", 32'h000300, 8'hA0, 1);
    rd_status("R7 opcode decoded after inhibited A0");
    wr_cfg(8'h40);
    // R11: abort mid-address
    cs_lo(); send(8'hEB, 0); send(8'h12, 1); send(8'h34, 1); cs_hi();
    rd_status("R11 status after abort");
    // R8: 4-byte addressing
    cmd(8'hB7); m_a4 = 1;
    rd_status("R8 status 4-byte");
    rd_fast("R8 read 4-byte address", 32'h01020304, 8'h00, 2);
    rd_status("R8 4-byte persists");
    // R10: AF ignored in extended mode
    cs_lo(); send(8'hAF, 0); quiet("R10 AF ignored in extended", 16); cs_hi();
    // R9: enter all-quad
    cmd(8'h35); m_qpi = 1;
    rd_status("R9 status quad 4-4-4");
    // R10: single-line and 9F ignored, AF works
    cs_lo(); send(8'h9F, 0); quiet("R10 single-line 9F ignored", 8); cs_hi();
    cs_lo(); send(8'h9F, 1); quiet("R10 quad 9F ignored", 8); cs_hi();
    cs_lo(); send(8'hAF, 1);
    recv("R10 quad id0", 1, 8'h20); recv("R10 quad id1", 1, 8'hBA); recv("R10 quad id2", 1, 8'h19);
    cs_hi();
    // R9 R6: 4-4-4 read and continuous read in quad
    rd_fast("R9 read 4-4-4", 32'h00000040, 8'hA0, 2);
    rd_fast("R6 keep with A5", 32'h00000080, 8'hA5, 2);
    rd_fast("R6 final address-first", 32'h000000C0, 8'h11, 2);
    rd_status("R6 R9 status quad after exit");
    cmd(8'hF5); m_qpi = 0;
    rd_status("R9 status after leaving quad");
    cmd(8'hE9); m_a4 = 0;
    rd_status("R8 status after leaving 4-byte");
    rd_fast("R8 R4 3-byte read again", 32'h00777777, 8'h00, 2);
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule